// File: doc/BRIEF.md
# Receive Lane Power-Up Sequencer

This block powers up one serial receive lane. It drives a 32-bit lane control word through a fixed series of bit edits. A single counter spaces the edits, and the block polls a calibration bit that the PHY clears by itself. A start pulse launches a run. The block then walks the lane through these stages in order:

1. It takes manual ownership of the lane.
2. It removes power-down, then wakes the lane.
3. It runs the calibration handshake, then turns on the data path.
4. It toggles PHY-ready around a clock-recovery reset, then lets the lane settle.

A lane that is already powered, either reported on an input or recorded by an earlier successful run, skips the first three stages. In the extended mode, an equalizer reset is applied together with the clock-recovery reset. The run then ends by handing over to an equalizer trainer instead of running the final settle.

Every wait is a clock-cycle count set by a parameter, and a wait parameter below 1 acts as 1. A calibration poll that runs out of attempts raises an error. After an error the control word is left exactly as it was at the point of failure.

Top module: `rxlane_seq`

## Requirements
- R1: After reset the control word is 0x00000007 (bit 0 main power-down, bit 1 auxiliary power-down, bit 2 sleep all set; every other bit clear). busy, done, error, hand-off and lane_up are all low.
- R2: From an unpowered lane, the override bit 31 is set one cycle after the start is sampled. Power-down bits 0 and 1 are cleared one cycle after that.
- R3: Sleep bit 2 is cleared max(T_SHORT,1) cycles after the power-down clear. Calibration bit 8 is set max(T_WAKE,1) cycles after that. Data-enable bit 3 is set max(T_SHORT,1) cycles after a successful poll.
- R4: The calibration readback is sampled every max(T_POLL,1) cycles after bit 8 is set, for at most POLL_TRIES samples. The first low sample ends the poll and clears bit 8 in the control word.
- R5: If the readback is still high at sample POLL_TRIES, error pulses for one cycle and busy drops in the same cycle. The control word is not changed, so bit 8 stays set.
- R6: When lane_pwr_i is high at start, PHY-ready bit 10 is cleared one cycle after the start, and bits 31, 3, 2, 1 and 0 are left untouched.
- R7: After bit 10 is cleared, clock-recovery reset bit 9 is set max(T_SHORT,1) cycles later. Bit 10 is set max(T_SHORT,1) cycles after that. Bit 9 is cleared max(T_SETTLE,1) cycles after that.
- R8: In the normal mode, done pulses for one cycle max(T_SETTLE,1) cycles after bit 9 is cleared, and busy falls in that same cycle. done, error and hand-off are never high together.
- R9: In the extended mode, equalizer-reset bit 12 is set in the same edit as bit 9 and stays set. eq_handoff_o pulses for one cycle in the cycle bit 9 is cleared, busy falls then, and done does not pulse.
- R10: A start pulse while busy has no effect. While idle with no start, the control word does not change.
- R11: Setting data-enable bit 3 raises lane_up_o. A later start then skips to the PHY-ready step even with lane_pwr_i low.
- R12: The mode is captured when the start is sampled; changing eq_mode_i during a run has no effect on that run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse, honoured only when idle |
| eq_mode_i | input | 1 | Selects the equalizer-reset and hand-off ending |
| lane_pwr_i | input | 1 | Lane is already powered, skip the early steps |
| cal_rdbk_i | input | 1 | Readback of the calibration bit from the PHY |
| ctrl_o | output | 32 | Lane control word |
| busy_o | output | 1 | A run is in progress |
| done_o | output | 1 | One-cycle pulse, run completed (normal mode) |
| err_o | output | 1 | One-cycle pulse, calibration poll timed out |
| eq_handoff_o | output | 1 | One-cycle pulse, control passes to the equalizer trainer |
| lane_up_o | output | 1 | Lane recorded as powered by this block |

## Verification
The bench aims at five corner cases, and each has a visible failure mode:

- **Poll timing.** The poll succeeds on its first sample or on its last, or it never succeeds. A wrong attempt count either raises the error one interval early or keeps polling past the limit.
- **Skip decision.** Both sources of the skip are exercised. A design that ignores its own record repeats the power-up edits on bits 31 and 0–3.
- **Extended mode.** The mode is flipped in mid-run. A design that does not capture it at start sets or omits bit 12 and ends with the wrong pulse.
- **Failed run.** The word after a failed run is compared bit for bit. A design that tidies up on error would drop bit 8.
- **Start while busy.** Start is held high throughout a run. A design that re-arms would restart the edits.

// File: rtl/rxl_pkg.sv
package rxl_pkg;
  localparam int unsigned WORD_W = 32;

  // Control word bit positions.
  localparam int unsigned B_PD    = 0;
  localparam int unsigned B_APD   = 1;
  localparam int unsigned B_SLEEP = 2;
  localparam int unsigned B_DEN   = 3;
  localparam int unsigned B_CAL   = 8;
  localparam int unsigned B_CDR   = 9;
  localparam int unsigned B_RDY   = 10;
  localparam int unsigned B_EQTR  = 11;
  localparam int unsigned B_EQRST = 12;
  localparam int unsigned B_OVR   = 31;

  localparam logic [WORD_W-1:0] WORD_RST = 32'h0000_0007;

  typedef enum logic [3:0] {
    ST_IDLE, ST_OVR, ST_PWR, ST_WAKE, ST_CAL, ST_POLL, ST_DATA,
    ST_RDY_LO, ST_CDR_ON, ST_RDY_HI, ST_CDR_OFF, ST_TAIL
  } seq_st_e;

  // One-hot mask for a control word bit.
  function automatic logic [WORD_W-1:0] bitm(input int unsigned n);
    return {{(WORD_W-1){1'b0}}, 1'b1} << n;
  endfunction

  // Counter load so that a step lands max(n,1) cycles after the previous one.
  function automatic int unsigned hold_len(input int unsigned n);
    return (n > 1) ? n - 1 : 0;
  endfunction

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/rxl_timer.sv
module rxl_timer #(
  parameter int unsigned CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld_i,
  input  logic [CW-1:0] ld_val_i,
  output logic          zero_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (ld_i)           cnt_q <= ld_val_i;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);

  // R3: an unloaded, running count drops by exactly one per cycle
  p_tmr_dec_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/rxl_poll.sv
module rxl_poll #(
  parameter int unsigned TRIES = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic bump_i,
  output logic last_o
);
  localparam int unsigned PW = $clog2(TRIES + 1);
  localparam logic [PW-1:0] LAST_IX = PW'(TRIES - 1);

  logic [PW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (bump_i) cnt_q <= cnt_q + 1'b1;
  end

  assign last_o = (cnt_q == LAST_IX);

  // R4: failed attempts never run past the attempt budget
  p_poll_cap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST_IX);
endmodule

// File: rtl/rxl_word.sv
module rxl_word #(
  parameter int unsigned W = 32,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_i,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] word_o
);
  logic [W-1:0] word_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    word_q <= RST_VAL;
    else if (wr_i) word_q <= (word_q & ~clr_i) | set_i;
  end

  assign word_o = word_q;
endmodule

// File: rtl/rxlane_seq.sv
module rxlane_seq #(
  parameter int unsigned T_SHORT    = 13,
  parameter int unsigned T_WAKE     = 125,
  parameter int unsigned T_POLL     = 250000,
  parameter int unsigned POLL_TRIES = 8,
  parameter int unsigned T_SETTLE   = 7500000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start_i,
  input  logic        eq_mode_i,
  input  logic        lane_pwr_i,
  input  logic        cal_rdbk_i,
  output logic [31:0] ctrl_o,
  output logic        busy_o,
  output logic        done_o,
  output logic        err_o,
  output logic        eq_handoff_o,
  output logic        lane_up_o
);
  import rxl_pkg::*;

  localparam int unsigned MAXD = max2(max2(T_SHORT, T_WAKE), max2(T_POLL, T_SETTLE));
  localparam int unsigned CW   = $clog2(MAXD + 2);
  localparam logic [CW-1:0] L_SHORT  = CW'(hold_len(T_SHORT));
  localparam logic [CW-1:0] L_WAKE   = CW'(hold_len(T_WAKE));
  localparam logic [CW-1:0] L_POLL   = CW'(hold_len(T_POLL));
  localparam logic [CW-1:0] L_SETTLE = CW'(hold_len(T_SETTLE));

  seq_st_e st_q, nxt;
  logic var_q, up_q, dn_q, er_q, ho_q;

  // Named internal events
  logic tmr_zero, step, poll_last;
  logic wr, ld, p_clr, p_bump, dn_d, er_d, ho_d, up_set, var_ld;
  logic [WORD_W-1:0] set_m, clr_m;
  logic [CW-1:0] ld_val;

  rxl_timer #(.CW(CW)) u_timer (
    .clk(clk), .rst_n(rst_n), .ld_i(ld), .ld_val_i(ld_val), .zero_o(tmr_zero)
  );

  rxl_poll #(.TRIES(POLL_TRIES)) u_poll (
    .clk(clk), .rst_n(rst_n), .clr_i(p_clr), .bump_i(p_bump), .last_o(poll_last)
  );

  rxl_word #(.W(WORD_W), .RST_VAL(WORD_RST)) u_word (
    .clk(clk), .rst_n(rst_n), .wr_i(wr), .set_i(set_m), .clr_i(clr_m), .word_o(ctrl_o)
  );

  assign step = (st_q != ST_IDLE) && tmr_zero;

  always_comb begin
    nxt = st_q; wr = 1'b0; set_m = '0; clr_m = '0; ld = 1'b0; ld_val = '0;
    p_clr = 1'b0; p_bump = 1'b0; dn_d = 1'b0; er_d = 1'b0; ho_d = 1'b0;
    up_set = 1'b0; var_ld = 1'b0;
    if (st_q == ST_IDLE) begin
      if (start_i) begin
        var_ld = 1'b1;
        ld     = 1'b1;
        nxt    = (lane_pwr_i || up_q) ? ST_RDY_LO : ST_OVR;
      end
    end else if (step) begin
      unique case (st_q)
        ST_OVR: begin
          wr = 1'b1; set_m = bitm(B_OVR); ld = 1'b1; nxt = ST_PWR;
        end
        ST_PWR: begin
          wr = 1'b1; clr_m = bitm(B_PD) | bitm(B_APD);
          ld = 1'b1; ld_val = L_SHORT; nxt = ST_WAKE;
        end
        ST_WAKE: begin
          wr = 1'b1; clr_m = bitm(B_SLEEP);
          ld = 1'b1; ld_val = L_WAKE; nxt = ST_CAL;
        end
        ST_CAL: begin
          wr = 1'b1; set_m = bitm(B_CAL); p_clr = 1'b1;
          ld = 1'b1; ld_val = L_POLL; nxt = ST_POLL;
        end
        ST_POLL: begin
          if (!cal_rdbk_i) begin
            wr = 1'b1; clr_m = bitm(B_CAL);
            ld = 1'b1; ld_val = L_SHORT; nxt = ST_DATA;
          end else if (poll_last) begin
            er_d = 1'b1; nxt = ST_IDLE;
          end else begin
            p_bump = 1'b1; ld = 1'b1; ld_val = L_POLL;
          end
        end
        ST_DATA: begin
          wr = 1'b1; set_m = bitm(B_DEN); up_set = 1'b1; ld = 1'b1; nxt = ST_RDY_LO;
        end
        ST_RDY_LO: begin
          wr = 1'b1; clr_m = bitm(B_RDY);
          ld = 1'b1; ld_val = L_SHORT; nxt = ST_CDR_ON;
        end
        ST_CDR_ON: begin
          wr = 1'b1; set_m = bitm(B_CDR) | (var_q ? bitm(B_EQRST) : '0);
          ld = 1'b1; ld_val = L_SHORT; nxt = ST_RDY_HI;
        end
        ST_RDY_HI: begin
          wr = 1'b1; set_m = bitm(B_RDY);
          ld = 1'b1; ld_val = L_SETTLE; nxt = ST_CDR_OFF;
        end
        ST_CDR_OFF: begin
          wr = 1'b1; clr_m = bitm(B_CDR);
          if (var_q) begin
            ho_d = 1'b1; nxt = ST_IDLE;
          end else begin
            ld = 1'b1; ld_val = L_SETTLE; nxt = ST_TAIL;
          end
        end
        ST_TAIL: begin
          dn_d = 1'b1; nxt = ST_IDLE;
        end
        default: nxt = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE; var_q <= 1'b0; up_q <= 1'b0;
      dn_q <= 1'b0; er_q <= 1'b0; ho_q <= 1'b0;
    end else begin
      st_q <= nxt;
      dn_q <= dn_d;
      er_q <= er_d;
      ho_q <= ho_d;
      if (var_ld) var_q <= eq_mode_i;
      if (up_set) up_q <= 1'b1;
    end
  end

  assign busy_o       = (st_q != ST_IDLE);
  assign done_o       = dn_q;
  assign err_o        = er_q;
  assign eq_handoff_o = ho_q;
  assign lane_up_o    = up_q;

  // R8: at most one ending pulse per cycle
  p_one_end_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({done_o, err_o, eq_handoff_o}));

  // R10: an idle block without a start keeps its word
  p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !start_i) |=> $stable(ctrl_o));

  // R5: a timeout leaves the calibration bit and the word as they were
  p_err_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> (ctrl_o[B_CAL] && $stable(ctrl_o)));

  // R2: data enable only ever rises with the override in place
  p_den_ovr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctrl_o[B_DEN]) |-> ctrl_o[B_OVR]);

  // R7: clock-recovery reset is released only while PHY-ready is set
  p_cdr_rel_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ctrl_o[B_CDR]) |-> ctrl_o[B_RDY]);

  // R9: equalizer reset and hand-off belong to the extended mode only
  p_eq_mode_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ctrl_o[B_EQRST]) || eq_handoff_o) |-> var_q);
endmodule

// File: tb/rxlane_seq_bench.sv
module rxlane_seq_bench;
  localparam int unsigned P_SHORT = 2;
  localparam int unsigned P_WAKE  = 3;
  localparam int unsigned P_POLL  = 4;
  localparam int unsigned P_TRIES = 3;
  localparam int unsigned P_SETTL = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0, eq_mode_i = 1'b0, lane_pwr_i = 1'b0, cal_rdbk_i = 1'b0;
  logic [31:0] ctrl_o;
  logic busy_o, done_o, err_o, eq_handoff_o, lane_up_o;

  always #2 clk = ~clk;

  rxlane_seq #(
    .T_SHORT(P_SHORT), .T_WAKE(P_WAKE), .T_POLL(P_POLL),
    .POLL_TRIES(P_TRIES), .T_SETTLE(P_SETTL)
  ) u_rxlane_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .eq_mode_i(eq_mode_i),
    .lane_pwr_i(lane_pwr_i), .cal_rdbk_i(cal_rdbk_i), .ctrl_o(ctrl_o),
    .busy_o(busy_o), .done_o(done_o), .err_o(err_o),
    .eq_handoff_o(eq_handoff_o), .lane_up_o(lane_up_o)
  );

  typedef struct {
    logic [31:0] c;
    logic b, d, e, h, p;
    logic st, rd, lp, vr;
    int rq;
  } ent_t;

  ent_t q[$];
  int checks = 0, errors = 0, cyc = 0;
  bit finished = 1'b0;

  // Reference model state
  logic [31:0] m_ctrl = 32'h7;
  logic m_pwr = 1'b0;
  logic sc_lp, sc_vr_late, sc_poke;
  int cur_rq = 1;

  function automatic string rq_name(input int n);
    case (n)
      1: return "R1";   2: return "R2";   3: return "R3";   4: return "R4";
      5: return "R5";   6: return "R6";   7: return "R7";   8: return "R8";
      9: return "R9";  10: return "R10"; 11: return "R11"; 12: return "R12";
      default: return "R?";
    endcase
  endfunction

  function automatic int gap(input int unsigned n);
    return (n < 1) ? 1 : int'(n);
  endfunction

  task automatic push(input logic b, d, e, h, st, rd, vr);
    ent_t x;
    x.c = m_ctrl; x.b = b; x.d = d; x.e = e; x.h = h; x.p = m_pwr;
    x.st = st; x.rd = rd; x.lp = sc_lp; x.vr = vr; x.rq = cur_rq;
    q.push_back(x);
  endtask

  task automatic hold(input int n, input logic rd);
    for (int i = 0; i < n; i++) push(1'b1, 1'b0, 1'b0, 1'b0, sc_poke, rd, sc_vr_late);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) push(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic finish_up();
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  // Build the expected trace of one run.
  task automatic run(input logic lp, vr, vr_late, poke, input int clr_at);
    bit skip, ok;
    sc_lp = lp; sc_vr_late = vr_late; sc_poke = poke;
    skip = lp || m_pwr;
    cur_rq = skip ? (lp ? 6 : 11) : 2;
    push(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, vr);
    hold(1, 1'b0);
    if (!skip) begin
      cur_rq = 2; m_ctrl[31] = 1'b1; hold(1, 1'b0);
      m_ctrl[1:0] = 2'b00; cur_rq = 3; hold(gap(P_SHORT), 1'b0);
      m_ctrl[2] = 1'b0; hold(gap(P_WAKE), 1'b0);
      m_ctrl[8] = 1'b1; cur_rq = 4; ok = 1'b0;
      for (int k = 1; k <= int'(P_TRIES); k++) begin
        hold(gap(P_POLL), (k == clr_at) ? 1'b0 : 1'b1);
        if (k == clr_at) begin ok = 1'b1; break; end
      end
      if (!ok) begin
        cur_rq = 5; push(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
        idle(3);
        return;
      end
      m_ctrl[8] = 1'b0; cur_rq = 3; hold(gap(P_SHORT), 1'b0);
      m_ctrl[3] = 1'b1; m_pwr = 1'b1; cur_rq = 11; hold(1, 1'b0);
    end
    cur_rq = 7; m_ctrl[10] = 1'b0; hold(gap(P_SHORT), 1'b0);
    m_ctrl[9] = 1'b1; if (vr) m_ctrl[12] = 1'b1;
    cur_rq = vr ? 9 : 7; hold(gap(P_SHORT), 1'b0);
    cur_rq = 7; m_ctrl[10] = 1'b1; hold(gap(P_SETTL), 1'b0);
    m_ctrl[9] = 1'b0;
    if (vr) begin
      cur_rq = 9; push(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
    end else begin
      cur_rq = 8; hold(gap(P_SETTL), 1'b0);
      push(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    end
    cur_rq = 10; idle(3);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    checks++;
    if (ctrl_o !== 32'h7 || busy_o !== 1'b0 || done_o !== 1'b0 || err_o !== 1'b0 ||
        eq_handoff_o !== 1'b0 || lane_up_o !== 1'b0) begin
      errors++;
      $display("FAIL R1 reset: ctrl=%h busy=%b done=%b err=%b ho=%b up=%b, expected ctrl=00000007 and all low",
               ctrl_o, busy_o, done_o, err_o, eq_handoff_o, lane_up_o);
    end
    rst_n = 1'b1;
    m_ctrl = 32'h7; m_pwr = 1'b0;
    @(posedge clk);
  endtask

  task automatic drain();
    wait (q.size() == 0);
    @(posedge clk);
  endtask

  // Per-cycle comparison and input drive, away from the active edge.
  initial begin
    forever begin
      @(negedge clk);
      if (q.size() > 0) begin
        ent_t e;
        e = q.pop_front();
        checks++;
        if (ctrl_o !== e.c || busy_o !== e.b || done_o !== e.d || err_o !== e.e ||
            eq_handoff_o !== e.h || lane_up_o !== e.p) begin
          errors++;
          $display("FAIL %s at cycle %0d: ctrl=%h busy=%b done=%b err=%b ho=%b up=%b, expected ctrl=%h busy=%b done=%b err=%b ho=%b up=%b",
                   rq_name(e.rq), cyc, ctrl_o, busy_o, done_o, err_o, eq_handoff_o, lane_up_o,
                   e.c, e.b, e.d, e.e, e.h, e.p);
        end
        start_i = e.st; cal_rdbk_i = e.rd; lane_pwr_i = e.lp; eq_mode_i = e.vr;
      end else begin
        start_i = 1'b0; cal_rdbk_i = 1'b0; lane_pwr_i = 1'b0; eq_mode_i = 1'b0;
      end
    end
  end

  // Watchdog
  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 20000) begin
        checks++; errors++;
        $display("FAIL watchdog: run still active at cycle %0d, expected end before 20000", cyc);
        finish_up();
      end
    end
  end

  initial begin
    do_reset();                       // R1
    run(1'b0, 1'b0, 1'b0, 1'b1, 2);   // R2 R3 R4 R7 R8, start held high while busy: R10
    drain();
    run(1'b0, 1'b0, 1'b0, 1'b0, 1);   // R11: recorded power skips the early steps
    drain();
    do_reset();
    run(1'b0, 1'b0, 1'b0, 1'b0, 0);   // R5: readback never clears
    drain();
    run(1'b1, 1'b1, 1'b0, 1'b0, 1);   // R6 skip via input, R9 extended mode, R12 mode dropped mid-run
    drain();
    do_reset();
    run(1'b0, 1'b1, 1'b0, 1'b0, 3);   // R4 success on last attempt, R9 full extended run
    drain();
    run(1'b0, 1'b0, 1'b1, 1'b0, 1);   // R12: mode raised after start is ignored
    drain();
    finish_up();
  end
endmodule